// File: doc/BRIEF.md
# SDRAM controller configuration registers

This block is the configuration and status register file of an SDRAM memory controller. Software reaches it through two locations on a simple register bus: one location holds a pointer into an internal register space, and the other reads or writes whichever internal register that pointer selects. Bus writes and reads are one-cycle strobes. Read data is registered and appears in the cycle after the read strobe.

The internal registers cover the following: two error status words and an error address, a global configuration word and a status word derived from it, a refresh timer, a power-management timer, one configuration word per memory bank, a timing word, and an ECC configuration and ECC status pair. Each register keeps only its own writable bits. The power timer also has forced-one bits. The error status words clear the bits written as one. A capture port lets the controller core log errors into them.

The bank words and the global enable bit go straight to an address decoder. A nonzero ECC status drives an interrupt line.

Top module: `sdram_cfg_regs`

## Requirements
- R1: The bus location at offset 0x10 is the pointer register. It resets to zero and reads back the last 32-bit value written to it.
- R2: A read or write at bus offset 0x11 reaches the internal register selected by the pointer. Read data appears on `rd_data` in the cycle after the `bus_rd` strobe. A read at any other bus offset returns zero.
- R3: The internal pointer values and their reset values are as follows. Configuration is 0x20 and resets to 0x00800000. Refresh timer is 0x30 and resets to 0x05F00000. Power timer is 0x34 and resets to 0x07C00000. Timing is 0x80 and resets to 0x00854009. Status is 0x24, error status 0 is 0x00, error status 1 is 0x08, error address is 0x10, ECC configuration is 0x94 and ECC status is 0x98; each of these resets to zero. Bank n configuration is at 0x40+4n and resets to zero.
- R4: A configuration write that takes bit 31 from 0 to 1 clears status bit 31, and one that takes it from 1 to 0 sets status bit 31. Output `ctrl_en` equals configuration bit 31.
- R5: A configuration write that takes bit 30 from 0 to 1 sets status bit 30, and one that takes it from 1 to 0 clears it. Writes to the status register have no effect.
- R6: Three registers keep only their writable bits. The timing word keeps only the bits in 0x018FC01F, the refresh timer only those in 0x3FF80000, and the ECC configuration only those in 0x00F00000.
- R7: A power timer write stores (data AND 0xF8000000) OR 0x07C00000. A bank write stores data AND 0xFFDEE001. Bank n is presented on `bank_cfg[32n+31:32n]`.
- R8: Writing an error status register clears the bits that are one in the written data. An `err_valid` pulse ORs `err_flags` into error status 0 (`err_sel`=0) or error status 1 (`err_sel`=1) and loads `err_addr` into the error address. The error address also takes plain writes.
- R9: `irq` is high in the cycle after a nonzero write to ECC status and stays high until a write of zero to ECC status, after which it is low from the next cycle.
- R10: A pointer value not listed in R3 reads as zero, and writes through it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus offset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_valid | input | 1 | Error capture strobe from the controller core |
| err_sel | input | 1 | Which error status word the capture targets |
| err_flags | input | 32 | Error bits to set |
| err_addr | input | 32 | Faulting address to log |
| ctrl_en | output | 1 | Global enable to the address decoder |
| bank_cfg | output | 32*NBANK | Bank configuration words, bank 0 in the low bits |
| irq | output | 1 | ECC error interrupt |

## Verification
Every register write takes effect at the clock edge that samples the strobe. Status, `ctrl_en`, `bank_cfg` and `irq` therefore change one cycle after a data-location write. Read data is due one cycle after the read strobe. The bench drives each strobe for exactly one cycle from the falling edge and samples at the next falling edge, by which point the due edge has passed and nothing further has moved. An indirect access costs one pointer write before the data access, and the bench always finishes both before it compares.

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PTR_OFS = 'h010,
  parameter logic [ADDR_W-1:0] DAT_OFS = 'h011,
  parameter int NBANK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic                 err_valid,
  input  logic                 err_sel,
  input  logic [31:0]          err_flags,
  input  logic [31:0]          err_addr,
  output logic                 ctrl_en,
  output logic [32*NBANK-1:0]  bank_cfg,
  output logic                 irq
);
  localparam logic [31:0] I_ES0 = 32'h00, I_ES1 = 32'h08, I_EADR = 32'h10;
  localparam logic [31:0] I_CFG = 32'h20, I_STAT = 32'h24, I_RTMR = 32'h30;
  localparam logic [31:0] I_PTMR = 32'h34, I_BANK = 32'h40, I_TIM = 32'h80;
  localparam logic [31:0] I_ECFG = 32'h94, I_ESTS = 32'h98;
  localparam logic [31:0] M_RTMR = 32'h3FF80000, M_TIM = 32'h018FC01F;
  localparam logic [31:0] M_ECFG = 32'h00F00000, M_PTMR = 32'hF8000000;
  localparam logic [31:0] F_PTMR = 32'h07C00000, M_BANK = 32'hFFDEE001;

  logic [31:0] ptr_q, es0_q, es1_q, eadr_q, cfg_q, stat_q, stat_nxt;
  logic [31:0] rtmr_q, ptmr_q, tim_q, ecfg_q, ests_q, sel_val;
  logic [31:0] bank_q [NBANK];

  wire wr_ptr = bus_wr && bus_addr == PTR_OFS;
  wire wr_dat = bus_wr && bus_addr == DAT_OFS;
  wire wr_cfg = wr_dat && ptr_q == I_CFG;

  always_comb begin
    stat_nxt = stat_q;
    if (!cfg_q[31] && wr_data[31]) stat_nxt[31] = 1'b0;
    else if (cfg_q[31] && !wr_data[31]) stat_nxt[31] = 1'b1;
    if (!cfg_q[30] && wr_data[30]) stat_nxt[30] = 1'b1;
    else if (cfg_q[30] && !wr_data[30]) stat_nxt[30] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      es0_q  <= '0;
      es1_q  <= '0;
      eadr_q <= '0;
      cfg_q  <= 32'h00800000;
      stat_q <= '0;
      rtmr_q <= 32'h05F00000;
      ptmr_q <= F_PTMR;
      tim_q  <= 32'h00854009;
      ecfg_q <= '0;
      ests_q <= '0;
    end else begin
      if (wr_ptr) ptr_q <= wr_data;
      es0_q <= (wr_dat && ptr_q == I_ES0 ? es0_q & ~wr_data : es0_q)
             | (err_valid && !err_sel ? err_flags : 32'h0);
      es1_q <= (wr_dat && ptr_q == I_ES1 ? es1_q & ~wr_data : es1_q)
             | (err_valid && err_sel ? err_flags : 32'h0);
      if (err_valid) eadr_q <= err_addr;
      else if (wr_dat && ptr_q == I_EADR) eadr_q <= wr_data;
      if (wr_cfg) begin
        cfg_q  <= wr_data;
        stat_q <= stat_nxt;
      end
      if (wr_dat && ptr_q == I_RTMR) rtmr_q <= wr_data & M_RTMR;
      if (wr_dat && ptr_q == I_PTMR) ptmr_q <= (wr_data & M_PTMR) | F_PTMR;
      if (wr_dat && ptr_q == I_TIM)  tim_q  <= wr_data & M_TIM;
      if (wr_dat && ptr_q == I_ECFG) ecfg_q <= wr_data & M_ECFG;
      if (wr_dat && ptr_q == I_ESTS) ests_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [31:0] I_THIS = I_BANK + 32'(4 * g);
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[g] <= '0;
      else if (wr_dat && ptr_q == I_THIS) bank_q[g] <= wr_data & M_BANK;
    end
    assign bank_cfg[32*g +: 32] = bank_q[g];

    p_bank_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q[g] & ~M_BANK) == 32'h0);
  end

  always_comb begin
    case (ptr_q)
      I_ES0:  sel_val = es0_q;
      I_ES1:  sel_val = es1_q;
      I_EADR: sel_val = eadr_q;
      I_CFG:  sel_val = cfg_q;
      I_STAT: sel_val = stat_q;
      I_RTMR: sel_val = rtmr_q;
      I_PTMR: sel_val = ptmr_q;
      I_TIM:  sel_val = tim_q;
      I_ECFG: sel_val = ecfg_q;
      I_ESTS: sel_val = ests_q;
      default: sel_val = '0;
    endcase
    for (int b = 0; b < NBANK; b++)
      if (ptr_q == I_BANK + 32'(4 * b)) sel_val = bank_q[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (bus_rd)
      rd_data <= bus_addr == PTR_OFS ? ptr_q :
                 bus_addr == DAT_OFS ? sel_val : 32'h0;
  end

  assign ctrl_en = cfg_q[31];
  assign irq     = ests_q != 32'h0;

  p_en_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[31]) |-> !stat_q[31]);
  p_en_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[31]) |-> stat_q[31]);
  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_q[30]) |-> stat_q[30]) and ($fell(cfg_q[30]) |-> !stat_q[30]));
  p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(stat_q));
  p_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rtmr_q & ~M_RTMR) | (tim_q & ~M_TIM) | (ecfg_q & ~M_ECFG)) == 32'h0);
  p_ptmr_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptmr_q & F_PTMR) == F_PTMR);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_q == I_ESTS && wr_data != 32'h0) |=> irq);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_q == I_ESTS && wr_data == 32'h0) |=> !irq);
endmodule

// File: tb/sdram_cfg_regs_tb.sv
module sdram_cfg_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic err_valid = 1'b0, err_sel = 1'b0;
  logic [31:0] err_flags = '0, err_addr = '0;
  logic ctrl_en, irq;
  logic [127:0] bank_cfg;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  sdram_cfg_regs u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .wr_data(wr_data), .rd_data(rd_data), .err_valid(err_valid),
    .err_sel(err_sel), .err_flags(err_flags), .err_addr(err_addr), .ctrl_en(ctrl_en),
    .bank_cfg(bank_cfg), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bwr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; wr_data = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = rd_data;
  endtask

  task automatic rwr(logic [31:0] idx, logic [31:0] d);
    bwr(10'h010, idx); bwr(10'h011, d);
  endtask

  task automatic rrd(logic [31:0] idx, output logic [31:0] d);
    bwr(10'h010, idx); brd(10'h011, d);
  endtask

  function automatic bit mapped(int i);
    return i inside {8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
                     8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98};
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h5A5A5A5A; pats[2] = 32'hA5A5A5A5; pats[3] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    brd(10'h010, v); chk("R1 ptr reset", v, 32'h0);
    rrd(32'h20, v); chk("R3 cfg reset", v, 32'h00800000);
    rrd(32'h30, v); chk("R3 refresh reset", v, 32'h05F00000);
    rrd(32'h34, v); chk("R3 power reset", v, 32'h07C00000);
    rrd(32'h80, v); chk("R3 timing reset", v, 32'h00854009);
    foreach (pats[k]) begin end
    for (int i = 0; i < 256; i += 4)
      if (mapped(i) && i != 8'h20 && i != 8'h30 && i != 8'h34 && i != 8'h80) begin
        rrd(i, v); chk($sformatf("R3 reset idx %h", i), v, 32'h0);
      end
    chk("R3 ctrl_en reset", {31'h0, ctrl_en}, 32'h0);
    chk("R3 irq reset", {31'h0, irq}, 32'h0);
    chk("R3 bank_cfg reset", bank_cfg[31:0] | bank_cfg[63:32] | bank_cfg[95:64] | bank_cfg[127:96], 32'h0);

    bwr(10'h010, 32'hDEADBEEF); brd(10'h010, v); chk("R1 ptr readback", v, 32'hDEADBEEF);
    brd(10'h012, v); chk("R2 other offset", v, 32'h0);
    brd(10'h000, v); chk("R2 other offset 0", v, 32'h0);

    for (int k = 0; k < 4; k++) begin
      rwr(32'h30, pats[k]); rrd(32'h30, v); chk("R6 refresh mask", v, pats[k] & 32'h3FF80000);
      rwr(32'h80, pats[k]); rrd(32'h80, v); chk("R6 timing mask", v, pats[k] & 32'h018FC01F);
      rwr(32'h94, pats[k]); rrd(32'h94, v); chk("R6 ecc cfg mask", v, pats[k] & 32'h00F00000);
      rwr(32'h34, pats[k]); rrd(32'h34, v);
      chk("R7 power timer", v, (pats[k] & 32'hF8000000) | 32'h07C00000);
      for (int b = 0; b < 4; b++) begin
        logic [31:0] d;
        d = pats[k] ^ (32'h11111111 * b);
        rwr(32'h40 + 4 * b, d); rrd(32'h40 + 4 * b, v);
        chk($sformatf("R7 bank %0d read", b), v, d & 32'hFFDEE001);
        chk($sformatf("R7 bank %0d port", b), bank_cfg[32*b +: 32], d & 32'hFFDEE001);
      end
    end

    rwr(32'h20, 32'h80000000); rrd(32'h24, v); chk("R4 enable rise", v, 32'h0);
    chk("R4 ctrl_en on", {31'h0, ctrl_en}, 32'h1);
    rwr(32'h20, 32'h00000000); rrd(32'h24, v); chk("R4 enable fall", v, 32'h80000000);
    chk("R4 ctrl_en off", {31'h0, ctrl_en}, 32'h0);
    rwr(32'h20, 32'hC0000000); rrd(32'h24, v); chk("R5 bit30 rise", v, 32'h40000000);
    rwr(32'h20, 32'h40000000); rrd(32'h24, v); chk("R4 fall keeps bit30", v, 32'hC0000000);
    rwr(32'h20, 32'h00000000); rrd(32'h24, v); chk("R5 bit30 fall", v, 32'h80000000);
    rwr(32'h24, 32'h0); rrd(32'h24, v); chk("R5 status ignores write", v, 32'h80000000);
    rwr(32'h20, 32'h00000000); rrd(32'h24, v); chk("R5 no edge no change", v, 32'h80000000);
    rrd(32'h20, v); chk("R2 cfg readback", v, 32'h0);

    @(negedge clk); err_valid = 1'b1; err_sel = 1'b0; err_flags = 32'hA5; err_addr = 32'h1234;
    @(negedge clk); err_sel = 1'b1; err_flags = 32'hF00; err_addr = 32'h5678;
    @(negedge clk); err_valid = 1'b0;
    rrd(32'h00, v); chk("R8 capture es0", v, 32'hA5);
    rrd(32'h08, v); chk("R8 capture es1", v, 32'hF00);
    rrd(32'h10, v); chk("R8 capture addr", v, 32'h5678);
    rwr(32'h00, 32'h05); rrd(32'h00, v); chk("R8 w1c es0", v, 32'hA0);
    rwr(32'h08, 32'h300); rrd(32'h08, v); chk("R8 w1c es1", v, 32'hC00);
    rwr(32'h10, 32'hCAFEF00D); rrd(32'h10, v); chk("R8 addr write", v, 32'hCAFEF00D);

    rwr(32'h98, 32'h10); chk("R9 irq set", {31'h0, irq}, 32'h1);
    rrd(32'h98, v); chk("R9 ecc status read", v, 32'h10);
    rwr(32'h98, 32'h3); chk("R9 irq stays", {31'h0, irq}, 32'h1);
    rwr(32'h98, 32'h0); chk("R9 irq clear", {31'h0, irq}, 32'h0);

    rwr(32'h30, 32'h12345678);
    for (int i = 0; i < 256; i++)
      if (!mapped(i)) begin
        rwr(i, 32'hFFFFFFFF); brd(10'h011, v);
        chk($sformatf("R10 unmapped %h", i), v, 32'h0);
      end
    rwr(32'h1000_0030, 32'hFFFFFFFF); brd(10'h011, v); chk("R10 wide unmapped", v, 32'h0);
    rrd(32'h30, v); chk("R10 refresh untouched", v, 32'h12345678 & 32'h3FF80000);
    rrd(32'h20, v); chk("R10 cfg untouched", v, 32'h0);
    chk("R10 irq untouched", {31'h0, irq}, 32'h0);
    chk("R10 bank0 untouched", bank_cfg[31:0], 32'h0 & 32'hFFDEE001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule